// File: doc/BRIEF.md
# E1 Timeslot-16 Signalling Extractor

This block sits behind the frame aligner of an E1 receiver. Each cycle with a valid strobe it is handed one received octet together with its timeslot number (0 to 31) and the number of its frame within the 16-frame signalling multiframe. It keeps the signalling and alignment octets and stores them at fixed positions of a 32-channel control stream. A read port then returns the stored byte for any control channel one clock later.

Timeslot 16 of frame 0 holds the multiframe alignment octet. It has four zero alignment bits, a far-end multiframe alarm bit and three spare bits. It is stored unchanged on control channel 0. Timeslot 16 of frame n (n from 1 to 15) carries the ABCD signalling nibbles of voice channels n and n+16, and it lands on control channel n. Timeslot 0 alternates between the frame alignment word and the non-frame alignment word. These two words are told apart by their second bit and are kept on channels 16 and 17. The upper channels carry nothing and read as all ones. Searching for multiframe alignment and the transmit direction are handled elsewhere.

Top module: `e1_sig_extract`

## Requirements
- R1: After reset, every control channel reads 8'hFF until a byte has been captured for it.
- R2: An octet received in timeslot 16 of frame 0 is stored bit-exact on channel 0. The first received bit is rx_octet[7] and appears as rd_data[7]. The alarm bit Y (rx_octet[2]) and the spares (rx_octet[3], rx_octet[1], rx_octet[0]) follow a single received value with no debouncing.
- R3: An octet received in timeslot 16 of frame n, for n from 1 to 15, is stored on channel n.
- R4: An octet received in timeslot 0 whose second bit (rx_octet[6]) is 0 is stored on channel 16 as the frame alignment word.
- R5: An octet received in timeslot 0 whose second bit (rx_octet[6]) is 1 is stored on channel 17 as the non-frame alignment word.
- R6: A stored byte is held until an octet for the same channel arrives later, and that octet then replaces it.
- R7: Octets in timeslots other than 0 and 16, and any cycle with rx_valid low, change no channel.
- R8: Channels 18 to 31 always read 8'hFF.
- R9: rd_data shows the channel that rd_chan selected at the previous rising edge. A read and a write to the same channel on the same edge return the content from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Qualifies the received octet in this cycle |
| rx_octet | input | 8 | Received octet, first bit in the MSB |
| rx_slot | input | 5 | Timeslot number of the octet |
| rx_frame | input | 4 | Frame number within the multiframe |
| rd_chan | input | 5 | Control channel to read |
| rd_data | output | 8 | Byte of the channel selected one cycle earlier |

## Verification
Every fault inside the block becomes visible only through the read port, one cycle after the channel is addressed. The bench therefore sweeps all 32 channels after reset and after each full multiframe. A wrong write address or a misread steering bit shows up as a byte on a neighbouring channel, or as a channel that stays at 8'hFF. A fill flag that is not cleared or is set by mistake turns an all-ones channel into stale RAM data. Junk octets on unused timeslots and unqualified cycles are interleaved, so a missing gate corrupts the next sweep.

// File: rtl/e1sx_pkg.sv
package e1sx_pkg;
  localparam int SIG_SLOT    = 16;
  localparam int ALIGN_SLOT  = 0;
  localparam int FAS_CH      = 16;
  localparam int NFAS_CH     = 17;
  localparam int LAST_CAP_CH = 17;
  localparam int STEER_BIT   = 6;
endpackage

// File: rtl/e1sx_slot_decode.sv
module e1sx_slot_decode #(
  parameter int OCT_W  = 8,
  parameter int SLOT_W = 5,
  parameter int FR_W   = 4,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [OCT_W-1:0]  rx_octet,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [FR_W-1:0]   rx_frame,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_addr,
  output logic [OCT_W-1:0]  wr_data
);
  import e1sx_pkg::*;

  logic hit_sig, hit_align;

  always_comb begin
    hit_sig   = rx_valid && (rx_slot == SLOT_W'(SIG_SLOT));
    hit_align = rx_valid && (rx_slot == SLOT_W'(ALIGN_SLOT));
    wr_en     = hit_sig || hit_align;
    wr_data   = rx_octet;
    if (hit_sig)
      wr_addr = CH_W'(rx_frame);
    else if (rx_octet[STEER_BIT])
      wr_addr = CH_W'(NFAS_CH);
    else
      wr_addr = CH_W'(FAS_CH);
  end

  AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= CH_W'(LAST_CAP_CH))); // R8
  AST_IDLE_NOWR: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> !wr_en); // R7
  AST_FAS_STEER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CH_W'(FAS_CH)) |-> (rx_slot == SLOT_W'(ALIGN_SLOT) && !rx_octet[STEER_BIT])); // R4
  AST_NFAS_STEER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CH_W'(NFAS_CH)) |-> (rx_slot == SLOT_W'(ALIGN_SLOT) && rx_octet[STEER_BIT])); // R5
endmodule

// File: rtl/e1sx_chan_ram.sv
module e1sx_chan_ram #(
  parameter int OCT_W = 8,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_addr,
  input  logic [OCT_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_addr,
  output logic [OCT_W-1:0] rd_q
);
  localparam int DEPTH = 1 << CH_W;

  logic [OCT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/e1sx_fill_flags.sv
module e1sx_fill_flags #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_addr,
  input  logic [CH_W-1:0] rd_addr,
  output logic            rd_filled
);
  localparam int DEPTH = 1 << CH_W;

  logic [DEPTH-1:0] filled;

  always_ff @(posedge clk) begin
    if (rst) begin
      filled    <= '0;
      rd_filled <= 1'b0;
    end else begin
      rd_filled <= filled[rd_addr];
      if (wr_en) filled[wr_addr] <= 1'b1;
    end
  end

  AST_FILL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wr_en) |=> filled[$past(wr_addr)]); // R6
endmodule

// File: rtl/e1_sig_extract.sv
module e1_sig_extract #(
  parameter int OCT_W  = 8,
  parameter int SLOT_W = 5,
  parameter int FR_W   = 4,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [OCT_W-1:0]  rx_octet,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [FR_W-1:0]   rx_frame,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [OCT_W-1:0]  rd_data
);
  import e1sx_pkg::*;

  logic              wr_en;
  logic [CH_W-1:0]   wr_addr;
  logic [OCT_W-1:0]  wr_data;
  logic [OCT_W-1:0]  ram_q;
  logic              rd_filled;

  e1sx_slot_decode #(.OCT_W(OCT_W), .SLOT_W(SLOT_W), .FR_W(FR_W), .CH_W(CH_W)) u_dec (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_octet(rx_octet),
    .rx_slot(rx_slot), .rx_frame(rx_frame),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  e1sx_chan_ram #(.OCT_W(OCT_W), .CH_W(CH_W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_chan), .rd_q(ram_q)
  );

  e1sx_fill_flags #(.CH_W(CH_W)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_chan), .rd_filled(rd_filled)
  );

  assign rd_data = rd_filled ? ram_q : '1;

  AST_HIGH_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_chan > CH_W'(LAST_CAP_CH)) |=> (rd_data == '1)); // R8
  AST_RST_ONES: assert property (@(posedge clk)
    rst |=> (rd_data == '1)); // R1
endmodule

// File: tb/e1_sig_extract_bench.sv
module e1_sig_extract_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_octet = '0;
  logic [4:0] rx_slot = '0;
  logic [3:0] rx_frame = '0;
  logic [4:0] rd_chan = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_mem [32];

  always #5 clk = ~clk;

  e1_sig_extract u_e1_sig_extract (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_octet(rx_octet),
    .rx_slot(rx_slot), .rx_frame(rx_frame), .rd_chan(rd_chan), .rd_data(rd_data)
  );

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int target(input int slot, input int frame, input logic [7:0] oct);
    if (slot == 16) return frame;
    if (slot == 0) return oct[6] ? 17 : 16;
    return -1;
  endfunction

  task automatic push(input logic v, input int slot, input int frame, input logic [7:0] oct);
    int t;
    @(negedge clk);
    rx_valid = v; rx_slot = 5'(slot); rx_frame = 4'(frame); rx_octet = oct;
    @(posedge clk);
    t = target(slot, frame, oct);
    if (v && t >= 0) exp_mem[t] = oct;
    #1 rx_valid = 1'b0;
  endtask

  task automatic check_chan(input int ch, input string req);
    @(negedge clk);
    rd_chan = 5'(ch);
    @(negedge clk);
    checks++;
    if (rd_data !== exp_mem[ch]) begin
      failures++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, rd_data, exp_mem[ch]);
    end
  endtask

  task automatic sweep(input string req);
    for (int c = 0; c < 32; c++) begin
      if (c >= 18) check_chan(c, "R8");
      else check_chan(c, req);
    end
  endtask

  task automatic multiframe(input int seed, input bit junk);
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 32; s++) begin
        logic [7:0] o;
        o = 8'((seed * 29 + f * 17 + s * 7) ^ (seed << 3));
        if (s == 0) o[6] = f[0];
        push(1'b1, s, f, o);
        if (junk && (s == 0 || s == 16)) push(1'b0, s, f, ~o);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 32; c++) exp_mem[c] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    sweep("R1");

    multiframe(1, 1'b0);
    sweep("R2 R3 R4 R5 R7");

    multiframe(5, 1'b1);
    sweep("R6 R7");

    push(1'b1, 16, 0, 8'b0000_0100);
    check_chan(0, "R2 Y set");
    push(1'b1, 16, 0, 8'b0000_1011);
    check_chan(0, "R2 Y clear spares");
    push(1'b1, 0, 3, 8'h1B);
    check_chan(16, "R4");
    push(1'b1, 0, 4, 8'h40);
    check_chan(17, "R5");
    push(1'b1, 9, 5, 8'h00);
    push(1'b0, 16, 5, 8'h00);
    check_chan(5, "R7");

    @(negedge clk);
    rd_chan = 5'd3; rx_valid = 1'b1; rx_slot = 5'd16; rx_frame = 4'd3; rx_octet = 8'hA5;
    @(negedge clk);
    rx_valid = 1'b0;
    checks++;
    if (rd_data !== exp_mem[3]) begin
      failures++;
      $display("FAIL R9 same-edge actual=%h expected=%h", rd_data, exp_mem[3]);
    end
    exp_mem[3] = 8'hA5;
    check_chan(3, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule